// File: doc/BRIEF.md
# Triple-Redundant Voter with Spare Module Replacement

This block votes three redundant copies of a data word and keeps the triad healthy by swapping in spare copies. Out of a pool of `3 + NSPARE` module outputs, three are routed through a registered switch into a bitwise two-of-three majority voter. On every valid cycle each routed word is compared with the voted word. A slot whose module disagrees is remapped to the next unused spare module, so that the vote keeps three good members until the spares are used up.

Spares are taken in ascending index order, and a retired module is never selected again. With the pool empty, a disagreeing module keeps its slot and voting continues. The block reports the vote, the current slot-to-module map, a flag that shows the pool is empty, and a one-cycle pulse for each cycle in which a disagreement was seen.

Top module: `tmr_spare_ctrl`

## Requirements
- R1: After reset, slot k (k = 0, 1, 2) holds module k, the next spare is module 3, `fault_pulse` and `voted_valid` are low, `voted` is zero, and `spares_empty` is low when NSPARE > 0.
- R2: One cycle after a cycle with `in_valid` high, `voted` holds the bitwise majority of the three routed module words and `voted_valid` is high. Module m drives `mod_data[m*W +: W]`.
- R3: If exactly one routed module disagrees with the majority on a valid cycle and a spare remains, its slot holds the next unused spare index on the following cycle. Slot k reads `slot_map[k*IW +: IW]`, where IW = $clog2(3+NSPARE).
- R4: Spares are assigned in strictly ascending index order. A module that has been replaced never returns to any slot, so later errors on it have no effect.
- R5: `fault_pulse` is high for exactly the one cycle after each valid cycle in which any routed module disagreed with the majority. This includes cycles when no spare remains.
- R6: `spares_empty` is high whenever every spare has been assigned. It then stays high. A disagreeing module keeps its slot while the vote continues.
- R7: If two slots disagree on the same valid cycle, only the lower-numbered slot is replaced. At most one slot changes per cycle.
- R8: On a cycle with `in_valid` low, the map and the spare state do not change, `fault_pulse` and `voted_valid` go low on the next cycle, and `voted` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Module words are valid this cycle |
| mod_data | input | (3+NSPARE)*W | All module words, module m at bits m*W +: W |
| voted | output | W | Registered majority word |
| voted_valid | output | 1 | `voted` was updated from a valid cycle |
| slot_map | output | 3*IW | Module index routed to each slot |
| spares_empty | output | 1 | No unused spare remains |
| fault_pulse | output | 1 | A disagreement was seen on the previous cycle |

## Verification
The hardest case to reach is two slots disagreeing in one cycle while the majority stays defined. The stimulus builds this by flipping a different bit in two routed modules, so that each bit still has two agreeing votes. The bench then uses up the last spare and keeps injecting errors. This shows that the map freezes while the pulse still fires. Corrupting a module that was retired earlier checks that it has no effect on the vote.

// File: rtl/tmr_spare_ctrl.sv
module tmr_spare_ctrl #(
  parameter int W      = 8,
  parameter int NSPARE = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [(3+NSPARE)*W-1:0]           mod_data,
  output logic [W-1:0]                      voted,
  output logic                              voted_valid,
  output logic [3*$clog2(3+NSPARE)-1:0]     slot_map,
  output logic                              spares_empty,
  output logic                              fault_pulse
);
  localparam int NMOD = 3 + NSPARE;
  localparam int IW   = $clog2(NMOD);
  localparam int PW   = $clog2(NMOD + 1);

  logic [IW-1:0] sel [3];
  logic [PW-1:0] nxt;
  logic [W-1:0]  sd  [3];
  logic [W-1:0]  maj;
  logic [2:0]    mis;
  logic [1:0]    pick;

  for (genvar k = 0; k < 3; k++) begin : g_slot
    assign sd[k]  = mod_data[sel[k]*W +: W];
    assign mis[k] = sd[k] != maj;
    assign slot_map[k*IW +: IW] = sel[k];
  end

  assign maj          = (sd[0] & sd[1]) | (sd[0] & sd[2]) | (sd[1] & sd[2]);
  assign pick         = mis[0] ? 2'd0 : (mis[1] ? 2'd1 : 2'd2);
  assign spares_empty = (nxt == PW'(NMOD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) sel[k] <= IW'(k);
      nxt         <= PW'(3);
      voted       <= '0;
      voted_valid <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      voted_valid <= in_valid;
      fault_pulse <= in_valid && (mis != 3'b000);
      if (in_valid) begin
        voted <= maj;
        if (mis != 3'b000 && !spares_empty) begin
          sel[pick] <= nxt[IW-1:0];
          nxt       <= nxt + PW'(1);
        end
      end
    end
  end

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(slot_map) && !fault_pulse && !voted_valid));

  assert_swap_has_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_map) |-> fault_pulse);

  assert_single_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel[0] != $past(sel[0]), sel[1] != $past(sel[1]),
                sel[2] != $past(sel[2])}) <= 1);

  assert_empty_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spares_empty) |-> spares_empty);

  assert_distinct_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[0] != sel[1]) && (sel[0] != sel[2]) && (sel[1] != sel[2]));
endmodule

// File: tb/tmr_spare_ctrl_bench.sv
module tmr_spare_ctrl_bench;
  localparam int W = 8, NSPARE = 3, NMOD = 3 + NSPARE, IW = $clog2(NMOD);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [NMOD*W-1:0] mod_data = '0;
  logic [W-1:0] voted;
  logic voted_valid, spares_empty, fault_pulse;
  logic [3*IW-1:0] slot_map;

  always #2 clk = ~clk;

  tmr_spare_ctrl #(.W(W), .NSPARE(NSPARE)) u_tmr_spare_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mod_data(mod_data),
    .voted(voted), .voted_valid(voted_valid), .slot_map(slot_map),
    .spares_empty(spares_empty), .fault_pulse(fault_pulse));

  int tests = 0, fails = 0;
  int mmap [3];
  int nspare;
  logic [W-1:0] exp_vote = '0;

  logic [W-1:0]    q_vote [$];
  logic            q_vv [$], q_empty [$], q_pulse [$];
  logic [3*IW-1:0] q_map [$];
  string           q_tag [$];

  function automatic logic [3*IW-1:0] pack_map();
    logic [3*IW-1:0] r;
    for (int k = 0; k < 3; k++) r[k*IW +: IW] = IW'(mmap[k]);
    return r;
  endfunction

  task automatic step(input logic v, input logic [W-1:0] vals [NMOD], input string tag);
    logic [W-1:0] a, b, c, mj;
    logic [2:0] mis;
    logic pulse;
    @(negedge clk);
    in_valid = v;
    for (int m = 0; m < NMOD; m++) mod_data[m*W +: W] = vals[m];
    a = vals[mmap[0]]; b = vals[mmap[1]]; c = vals[mmap[2]];
    mj = (a & b) | (a & c) | (b & c);
    mis = {c != mj, b != mj, a != mj};
    pulse = v && (mis != 3'b000);
    if (v) begin
      exp_vote = mj;
      if (mis != 3'b000 && nspare < NMOD) begin
        if (mis[0]) mmap[0] = nspare;
        else if (mis[1]) mmap[1] = nspare;
        else mmap[2] = nspare;
        nspare++;
      end
    end
    q_vote.push_back(exp_vote); q_vv.push_back(v);
    q_map.push_back(pack_map()); q_empty.push_back(nspare == NMOD);
    q_pulse.push_back(pulse); q_tag.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q_tag.size() > 0) begin
        logic [W-1:0] ev; logic evv, ee, ep; logic [3*IW-1:0] em; string t;
        ev = q_vote.pop_front(); evv = q_vv.pop_front(); em = q_map.pop_front();
        ee = q_empty.pop_front(); ep = q_pulse.pop_front(); t = q_tag.pop_front();
        tests++;
        if (voted !== ev || voted_valid !== evv || slot_map !== em ||
            spares_empty !== ee || fault_pulse !== ep) begin
          fails++;
          $display("FAIL %s: got vote=%h vv=%b map=%h empty=%b pulse=%b, exp vote=%h vv=%b map=%h empty=%b pulse=%b",
                   t, voted, voted_valid, slot_map, spares_empty, fault_pulse, ev, evv, em, ee, ep);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v [NMOD];
    for (int k = 0; k < 3; k++) mmap[k] = k;
    nspare = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    tests++;
    if (slot_map !== {IW'(2), IW'(1), IW'(0)} || spares_empty !== 1'b0 ||
        fault_pulse !== 1'b0 || voted_valid !== 1'b0 || voted !== '0) begin
      fails++;
      $display("FAIL R1: got map=%h empty=%b pulse=%b vv=%b vote=%h, exp map=%h empty=0 pulse=0 vv=0 vote=0",
               slot_map, spares_empty, fault_pulse, voted_valid, voted, {IW'(2), IW'(1), IW'(0)});
    end

    for (int m = 0; m < NMOD; m++) v[m] = 8'h5A;
    step(1, v, "R2 all agree");
    for (int m = 0; m < NMOD; m++) v[m] = 8'hC3;
    step(1, v, "R2 second pattern");
    v[0] = 8'hF0; v[1] = 8'hCC; v[2] = 8'hAA;
    step(0, v, "R8 invalid ignored");
    for (int m = 0; m < NMOD; m++) v[m] = 8'h3C;
    v[1] = 8'h00;
    step(1, v, "R3 slot1 replaced by spare 3");
    step(1, v, "R4 retired module 1 ignored");
    v[1] = 8'h3C; v[0] = 8'h3D; v[2] = 8'h3E;
    step(1, v, "R7 two disagree, slot0 gets 4");
    v[0] = 8'h3C; v[2] = 8'h3C; v[4] = 8'h3C;
    step(1, v, "R4 module0 retired, module2 ok");
    v[3] = 8'hFF;
    step(0, v, "R8 invalid with bad data");
    step(1, v, "R6 last spare used, empty");
    v[4] = 8'h00; v[3] = 8'h3C;
    step(1, v, "R6 no spare, pulse, map frozen");
    v[4] = 8'h3C; v[5] = 8'h81;
    step(1, v, "R5 pulse while empty");
    v[5] = 8'h3C;
    step(1, v, "R2 clean vote after empty");
    step(0, v, "R8 idle drain");
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule